// File: doc/BRIEF.md
# Receive Word FIFO with Hysteretic Almost-Full

This block is a single-clock synchronous FIFO that holds received data words until a user-side reader fetches them. Words enter through a plain write port (a write strobe plus data) that stands in for an upstream receive interface. They leave through a read port with an active-low read enable. Read data is registered, and a valid strobe marks each cycle in which the read bus carries a genuine word.

Three active-low status flags describe the occupancy: empty, almost-empty (exactly one word left) and almost-full. The almost-full flag has hysteresis. Two static threshold inputs, both given as a count of free locations, set where it turns on and where it turns off. An upstream sender can therefore be throttled without the flag chattering around a single level. The word width is a parameter: 64 bits holds 8 bytes per entry and 32 bits holds 4 bytes per entry. The depth is a power-of-two parameter.

Top module: `rx_word_fifo`

## Requirements
- R1: While reset is held and in the first cycle after reset, `empty_n`=0, `aempty_n`=1, `afull_n`=1 and `rd_valid`=0.
- R2: Words leave in the order they were written. A read enable sampled low at a clock edge while the FIFO holds data puts the oldest word on `rd_data` with `rd_valid`=1 in the cycle that follows that edge.
- R3: `rd_valid` is 1 only in a cycle that follows an accepted read. It is 0 after a cycle with no read, and 0 after a read attempted while empty.
- R4: `empty_n` is 0 exactly when no word is stored. It goes low in the same cycle that the last stored word appears on `rd_data`.
- R5: `aempty_n` is 0 exactly when one word is stored. A single one-cycle read then delivers that word.
- R6: `afull_n` goes to 0 as soon as the number of free locations is at or below `af_on_free`.
- R7: Once `afull_n` is 0, it returns to 1 only when the free count rises above `af_off_free`. With the free count between the two thresholds, the flag keeps its previous value. `af_off_free` must be at least `af_on_free`.
- R8: A write while all DEPTH locations are full is ignored. That word is never read out, and the stored words are unchanged.
- R9: A read while empty is ignored. The pointers and count do not move, and a word written later is read back correctly.
- R10: A write and a read may occur at the same edge. When one word is stored, that pair delivers the old word and leaves the FIFO holding the new one, with `empty_n`=1 and `aempty_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, active high |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| af_on_free | input | $clog2(DEPTH)+1 | Free-location level at or below which almost-full turns on |
| af_off_free | input | $clog2(DEPTH)+1 | Free-location level above which almost-full turns off |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | High when rd_data carries a word read out of the FIFO |
| empty_n | output | 1 | Low when the FIFO is empty |
| aempty_n | output | 1 | Low when exactly one word is stored |
| afull_n | output | 1 | Low when almost full, with hysteresis |

## Verification
A short write-then-drain burst with distinct words checks ordering, and also where the valid strobe and the empty flag land relative to the last word. A slow fill to full followed by a drain and a partial refill sweeps the free count through both thresholds. This shows whether the flag turns off at the negate level, at the assert level, or in between. Writes against a full FIFO and reads against an empty one show whether a blocked access leaks into storage. A combined read and write with a single word stored separates designs that compute empty from the pre-access count from those that use the resulting count.

// File: rtl/rx_fifo_pkg.sv
// Package: rx_fifo_pkg
// Shared defaults and the status-flag bundle for the receive word FIFO.
// Assumes: flags in the bundle are active low, as seen at the top ports.
package rx_fifo_pkg;

    // default word width (64 bits holds 8 bytes per entry; 32 holds 4)
    localparam int DEF_DATA_W = 64;
    // default depth in words, must be a power of two
    localparam int DEF_DEPTH  = 16;

    // active-low occupancy flags produced together
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
        logic afull_n;
    } fifo_flags_t;

    // flag values shown after reset: empty, not almost-empty, not almost-full
    localparam fifo_flags_t FLAGS_RESET = '{empty_n: 1'b0, aempty_n: 1'b1, afull_n: 1'b1};

endpackage

// File: rtl/fifo_ptr_ctrl.sv
// Module: fifo_ptr_ctrl
// Keeps the write and read pointers and the occupancy count. It decides which
// requested accesses are accepted: a write is refused when full and a read is
// refused when empty. It also presents the count that follows this edge, so
// the flag logic can register flags that match the resulting occupancy.
// Assumes: DEPTH is a power of two, so pointers wrap naturally.
module fifo_ptr_ctrl #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nxt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic is_full;
    logic is_empty;

    // occupancy decode of the current count
    always_comb begin
        is_full  = (count == FULL_CNT);
        is_empty = (count == '0);
    end

    // accept an access only when it cannot overflow or underflow
    always_comb begin
        wr_ok = wr_req && !is_full;
        rd_ok = rd_req && !is_empty;
    end

    // count after this edge, from the accepted accesses
    always_comb begin
        unique case ({wr_ok, rd_ok})
            2'b10:   count_nxt = count + 1'b1;
            2'b01:   count_nxt = count - 1'b1;
            default: count_nxt = count;
        endcase
    end

    // pointer and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            count <= count_nxt;
        end
    end

    // R8: the count never exceeds the depth
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R8: a write against a full FIFO with no read leaves the write pointer still
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_req && !rd_req) |=> ($stable(wr_ptr) && count == FULL_CNT));

    // R9: a read against an empty FIFO with no write moves nothing
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_req && !wr_req) |=> ($stable(rd_ptr) && count == '0));

    // R9: pointers separate only by the stored count
    p_ptr_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ADDR_W'(wr_ptr - rd_ptr) == ADDR_W'(count));

endmodule

// File: rtl/fifo_store.sv
// Module: fifo_store
// Word storage with a registered read port. An accepted write stores at the
// write pointer. An accepted read loads the word at the read pointer into the
// output register and raises the valid strobe for one cycle.
// Assumes: the pointer logic never accepts a write and a read at the same
// location in one edge (the read needs a stored word, the write needs a free slot).
module fifo_store #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] mem [DEPTH];

    // array write, no reset on storage
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // registered read word and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (rd_ok) rd_data <= mem[rd_ptr];
            rd_valid <= rd_ok;
        end
    end

    // R2: read data changes only in a cycle that carries a new word
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data) || $past(!rst_n));

endmodule

// File: rtl/fifo_flag_gen.sv
// Module: fifo_flag_gen
// Registers the active-low status flags from the count that follows each edge,
// so each flag matches the occupancy that the read port shows in the same cycle.
// Almost-full uses two free-location levels: it turns on at or below the on
// level, turns off above the off level, and holds its value in between.
// Assumes: off level >= on level; thresholds are static during operation.
module fifo_flag_gen
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic [CNT_W-1:0] on_free,
    input  logic [CNT_W-1:0] off_free,
    output fifo_flags_t      flags
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_nxt;
    fifo_flags_t      flags_nxt;

    // free locations after this edge
    always_comb free_nxt = FULL_CNT - count_nxt;

    // next flag values, with hysteresis on almost-full
    always_comb begin
        flags_nxt.empty_n  = (count_nxt != '0);
        flags_nxt.aempty_n = (count_nxt != CNT_W'(1));
        if (free_nxt <= on_free)
            flags_nxt.afull_n = 1'b0;
        else if (free_nxt > off_free)
            flags_nxt.afull_n = 1'b1;
        else
            flags_nxt.afull_n = flags.afull_n;
    end

    // flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= FLAGS_RESET;
        else        flags <= flags_nxt;
    end

    // R4/R5: empty and almost-empty are never active together
    p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags.empty_n || flags.aempty_n);

endmodule

// File: rtl/rx_word_fifo.sv
// Module: rx_word_fifo (top)
// Single-clock receive word FIFO with registered read data, a valid strobe,
// and active-low empty, almost-empty and hysteretic almost-full flags.
// Assumes: DEPTH is a power of two; DATA_W is 32 or 64; af_off_free is at
// least af_on_free and both stay static while running.
module rx_word_fifo
    import rx_fifo_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic [CNT_W-1:0]  af_on_free,
    input  logic [CNT_W-1:0]  af_off_free,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              afull_n
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic              rd_req;
    logic              wr_ok;
    logic              rd_ok;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  count_nxt;
    fifo_flags_t       flags;

    // active-high internal read request
    always_comb rd_req = !rd_en_n;

    fifo_ptr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_en),
        .rd_req    (rd_req),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .count_nxt (count_nxt)
    );

    fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .wr_ptr   (wr_ptr),
        .wr_data  (wr_data),
        .rd_ok    (rd_ok),
        .rd_ptr   (rd_ptr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    fifo_flag_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_nxt (count_nxt),
        .on_free   (af_on_free),
        .off_free  (af_off_free),
        .flags     (flags)
    );

    // expose flag bundle on the ports
    always_comb begin
        empty_n  = flags.empty_n;
        aempty_n = flags.aempty_n;
        afull_n  = flags.afull_n;
    end

    // R4: empty flag matches a zero count
    p_empty_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n) == (count == '0));

    // R5: almost-empty flag matches a count of one
    p_aempty_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!aempty_n) == (count == CNT_W'(1)));

    // R2: a read request seen while non-empty yields a valid word next cycle
    p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty_n) |=> rd_valid);

    // R3: a read request against an empty FIFO yields no valid word
    p_no_valid_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !empty_n) |=> !rd_valid);

    // R6: almost-full is active whenever free space is at or below the on level
    p_afull_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((FULL_CNT - count) <= af_on_free) |-> !afull_n);

    // R7: almost-full clears only with free space above the off level
    p_afull_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(afull_n) |-> ((FULL_CNT - count) > af_off_free));

    // R7: thresholds are ordered
    p_thr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        af_off_free >= af_on_free);

endmodule

// File: tb/tb_rx_word_fifo.sv
// Directed bench for rx_word_fifo: one task per scenario, each checking its results.
module tb_rx_word_fifo;

    localparam int DATA_W = 64;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = $clog2(DEPTH) + 1;
    localparam int ON_LVL  = 4;
    localparam int OFF_LVL = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en_n = 1'b1;
    logic [CNT_W-1:0]  af_on_free  = CNT_W'(ON_LVL);
    logic [CNT_W-1:0]  af_off_free = CNT_W'(OFF_LVL);
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              empty_n;
    logic              aempty_n;
    logic              afull_n;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [DATA_W-1:0] q [$];
    logic [DATA_W-1:0] m_word = '0;
    logic              m_valid = 1'b0;
    logic              m_af_n = 1'b1;

    always #5 clk = ~clk;

    rx_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .af_on_free(af_on_free), .af_off_free(af_off_free),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock with the given accesses; model updated, all outputs compared
    task automatic cyc(input bit w, input logic [DATA_W-1:0] d, input bit r);
        int free;
        bit rok, wok;
        wr_en = w; wr_data = d; rd_en_n = !r;
        rok = r && (q.size() > 0);
        wok = w && (q.size() < DEPTH);
        if (rok) m_word = q.pop_front();
        m_valid = rok;
        if (wok) q.push_back(d);
        free = DEPTH - q.size();
        if (free <= ON_LVL) m_af_n = 1'b0;
        else if (free > OFF_LVL) m_af_n = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en_n = 1'b1;
        chk(DATA_W'(rd_valid), DATA_W'(m_valid), "R3 rd_valid");
        if (m_valid) chk(rd_data, m_word, "R2 rd_data order");
        chk(DATA_W'(empty_n), DATA_W'(q.size() != 0), "R4 empty_n");
        chk(DATA_W'(aempty_n), DATA_W'(q.size() != 1), "R5 aempty_n");
        chk(DATA_W'(afull_n), DATA_W'(m_af_n), "R6/R7 afull_n");
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(DATA_W'({empty_n, aempty_n, afull_n, rd_valid}), DATA_W'(4'b0110), "R1 flags in reset");
        rst_n = 1'b1;
        q.delete(); m_valid = 1'b0; m_af_n = 1'b1;
        @(posedge clk); #1;
        chk(DATA_W'({empty_n, aempty_n, afull_n, rd_valid}), DATA_W'(4'b0110), "R1 flags after reset");
    endtask

    task automatic t_order_r2();
        for (int i = 0; i < 5; i++) cyc(1'b1, 64'hA000_0000_0000_0000 + DATA_W'(i * 17), 1'b0);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, '0, 1'b1);
            chk(rd_data, 64'hA000_0000_0000_0000 + DATA_W'(i * 17), "R2 fifo order");
        end
        cyc(1'b0, '0, 1'b0);
        chk(DATA_W'(rd_valid), '0, "R3 valid drops when idle");
    endtask

    task automatic t_last_word_r4();
        cyc(1'b1, 64'h1111, 1'b0);
        cyc(1'b1, 64'h2222, 1'b0);
        cyc(1'b0, '0, 1'b1);
        chk(DATA_W'({empty_n, aempty_n}), DATA_W'(2'b10), "R5 one word left");
        cyc(1'b0, '0, 1'b1);
        chk(DATA_W'({rd_valid, empty_n, aempty_n}), DATA_W'(3'b101), "R4 empty with last word");
        chk(rd_data, 64'h2222, "R5 last word delivered");
    endtask

    task automatic t_read_empty_r9();
        cyc(1'b0, '0, 1'b1);
        chk(DATA_W'(rd_valid), '0, "R9 read on empty no valid");
        cyc(1'b0, '0, 1'b1);
        cyc(1'b1, 64'h5A5A, 1'b0);
        cyc(1'b0, '0, 1'b1);
        chk(rd_data, 64'h5A5A, "R9 word after empty reads");
        chk(DATA_W'(empty_n), '0, "R9 empty again");
    endtask

    task automatic t_hyst_r7();
        for (int i = 0; i < 11; i++) cyc(1'b1, DATA_W'(100 + i), 1'b0);
        chk(DATA_W'(afull_n), DATA_W'(1), "R6 free 5 not almost-full");
        cyc(1'b1, DATA_W'(111), 1'b0);
        chk(DATA_W'(afull_n), '0, "R6 free 4 almost-full");
        for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b1);
        chk(DATA_W'(afull_n), '0, "R7 free 8 holds");
        cyc(1'b0, '0, 1'b1);
        chk(DATA_W'(afull_n), DATA_W'(1), "R7 free 9 clears");
        cyc(1'b1, DATA_W'(200), 1'b0);
        chk(DATA_W'(afull_n), DATA_W'(1), "R7 free 8 stays clear");
        while (q.size() > 0) cyc(1'b0, '0, 1'b1);
    endtask

    task automatic t_overflow_r8();
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, DATA_W'(300 + i), 1'b0);
        cyc(1'b1, 64'hDEAD, 1'b0);
        cyc(1'b1, 64'hBEEF, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b0, '0, 1'b1);
            chk(rd_data, DATA_W'(300 + i), "R8 stored words intact");
        end
        chk(DATA_W'(empty_n), '0, "R8 dropped words absent");
    endtask

    task automatic t_simul_r10();
        cyc(1'b1, 64'h7777, 1'b0);
        cyc(1'b1, 64'h8888, 1'b1);
        chk(rd_data, 64'h7777, "R10 old word out");
        chk(DATA_W'({empty_n, aempty_n}), DATA_W'(2'b10), "R10 new word kept");
        cyc(1'b0, '0, 1'b1);
        chk(rd_data, 64'h8888, "R10 new word out");
    endtask

    initial begin
        t_reset_r1();
        t_order_r2();
        t_last_word_r4();
        t_read_empty_r9();
        t_hyst_r7();
        t_overflow_r8();
        t_simul_r10();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule